// File: doc/BRIEF.md
# Stacked-Die Channel and Die Address Dehasher

This block turns a hashed system address back into a normalized address for a memory map in which consecutive lines are spread over many channels and over several stacked dies. Each channel-select bit and each die-select bit of the address was folded, on the way in, with the XOR of a set of higher address bits. Five hash enables pick those bits, one per granule size: 4 KiB, 64 KiB, 2 MiB, 1 GiB and 1 TiB. The block undoes the fold by flipping each select bit whenever the XOR of its enabled terms is one.

The caller presents one address per cycle together with the map settings: the channel interleave count (8, 16 or 32), the die interleave count (1, 2 or 4), the five enables, the interleave start position and the socket count. One cycle later the corrected address appears with a valid strobe. If the settings describe a map that this scheme cannot handle, the address is passed through unchanged and an error flag is raised.

Top module: `stack_dehash`

## Requirements
- R1: A request whose interleave position is not 8, whose socket count is above 1, or whose die count is not 1, 2 or 4 gives out_err = 1 with out_addr equal to in_addr.
- R2: A request whose channel count is not 8, 16 or 32 gives out_err = 1 with out_addr equal to in_addr; a valid setting gives out_err = 0.
- R3: log2(channel count) channel bits are corrected; channel bit i lives at address bit 8+i for i of 0 to 3 and at address bit 14 for i = 4, and no other channel bit is touched.
- R4: Enable bit 0 (4K) adds address bit 12+i to channel bit i only for i of 0, 1 and 2.
- R5: Channel bit i also takes bit 15+i under enable bit 1 (64K), bit 22+i under enable bit 2 (2M), bit 29+i under enable bit 3 (1G), and both bits 36+i and 43+i under enable bit 4 (1T).
- R6: log2(die count) die bits at address bits 12+i are corrected, with terms 20+i (64K), 27+i (2M), 34+i (1G) and 41+i (1T); the 4K enable has no die term.
- R7: Channel bits are corrected before die bits, each step on the running address, and a select bit flips exactly when the XOR of its enabled terms is 1.
- R8: Only address bits 8 to 14 can change; with all enables clear, a valid request comes out unchanged.
- R9: out_valid is in_valid delayed by one clock and is 0 after reset; out_addr and out_err load only on a valid request and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Hashed address |
| in_chan_cnt | input | 6 | Channel interleave count (8, 16, 32) |
| in_die_cnt | input | 3 | Die interleave count (1, 2, 4) |
| in_hash_en | input | 5 | Enables: bit0 4K, bit1 64K, bit2 2M, bit3 1G, bit4 1T |
| in_ilv_pos | input | 6 | Interleave start bit position (must be 8) |
| in_sock_cnt | input | 2 | Socket interleave count (at most 1) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_addr | output | 64 | Dehashed address |
| out_err | output | 1 | Settings not supported; address passed through |

## Verification
The assertions take in_valid and every map setting to be known (not X) whenever rst_n is high, and they judge a result against the inputs of the cycle before, so they rely on the request being held for exactly the one edge at which it is taken. The bench drives every input on the falling edge from tasks, keeps all settings at defined values even when in_valid is low, and only changes them between edges, so each sampled request is the one the properties compare against.

// File: rtl/dhx_pkg.sv
package dhx_pkg;
  localparam int ADDR_W        = 64;
  localparam int CHAN_MAX_BITS = 5;
  localparam int DIE_MAX_BITS  = 2;
  localparam int NUM_EN        = 5;
  localparam int NUM_STAGES    = CHAN_MAX_BITS + DIE_MAX_BITS;

  typedef enum int {EN_4K = 0, EN_64K = 1, EN_2M = 2, EN_1G = 3, EN_1T = 4} hash_en_idx_e;

  // Channel select bits sit at 8,9,10,11 and then jump to 14.
  function automatic int chan_base(input int i);
    return (i == 4) ? 14 : 8 + i;
  endfunction

  // The 4K granule only folds into the three lowest channel bits.
  function automatic int chan_t4k(input int i);
    return (i <= 2) ? 12 + i : -1;
  endfunction
endpackage

// File: rtl/dhx_check.sv
module dhx_check
  import dhx_pkg::*;
(
  input  logic [5:0] chan_cnt,
  input  logic [2:0] die_cnt,
  input  logic [5:0] ilv_pos,
  input  logic [1:0] sock_cnt,
  output logic       err,
  output logic [2:0] chan_bits,
  output logic [1:0] die_bits
);
  logic chan_ok, die_ok;

  always_comb begin
    chan_ok   = 1'b1;
    chan_bits = 3'd0;
    unique case (chan_cnt)
      6'd8:    chan_bits = 3'd3;
      6'd16:   chan_bits = 3'd4;
      6'd32:   chan_bits = 3'd5;
      default: chan_ok   = 1'b0;
    endcase

    die_ok   = 1'b1;
    die_bits = 2'd0;
    unique case (die_cnt)
      3'd1:    die_bits = 2'd0;
      3'd2:    die_bits = 2'd1;
      3'd4:    die_bits = 2'd2;
      default: die_ok   = 1'b0;
    endcase

    err = !chan_ok || !die_ok || (ilv_pos != 6'd8) || (sock_cnt > 2'd1);
  end
endmodule

// File: rtl/dhx_fix_bit.sv
module dhx_fix_bit
  import dhx_pkg::*;
#(
  parameter int BASE  = 8,
  parameter int T4K   = -1,
  parameter int T64K  = 15,
  parameter int T2M   = 22,
  parameter int T1G   = 29,
  parameter int T1TA  = 36,
  parameter int T1TB  = -1
) (
  input  logic              act,
  input  logic [NUM_EN-1:0] en,
  input  logic [ADDR_W-1:0] a_i,
  output logic [ADDR_W-1:0] a_o
);
  logic t4k, t1tb, flip;

  if (T4K >= 0) begin : g_t4k
    assign t4k = a_i[T4K];
  end else begin : g_no_t4k
    assign t4k = 1'b0;
  end

  if (T1TB >= 0) begin : g_t1tb
    assign t1tb = a_i[T1TB];
  end else begin : g_no_t1tb
    assign t1tb = 1'b0;
  end

  always_comb begin
    flip = act & ((en[EN_4K]  & t4k)
                ^ (en[EN_64K] & a_i[T64K])
                ^ (en[EN_2M]  & a_i[T2M])
                ^ (en[EN_1G]  & a_i[T1G])
                ^ (en[EN_1T]  & (a_i[T1TA] ^ t1tb)));
    a_o       = a_i;
    a_o[BASE] = a_i[BASE] ^ flip;
  end
endmodule

// File: rtl/dhx_oreg.sv
module dhx_oreg
  import dhx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_err,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_err
);
  logic              valid_nxt, err_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    valid_nxt = ld;
    addr_nxt  = q_addr;
    err_nxt   = q_err;
    if (ld) begin
      addr_nxt = d_addr;
      err_nxt  = d_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_err   <= 1'b0;
    end else begin
      q_valid <= valid_nxt;
      q_addr  <= addr_nxt;
      q_err   <= err_nxt;
    end
  end
endmodule

// File: rtl/stack_dehash.sv
module stack_dehash
  import dhx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       in_addr,
  input  logic [5:0]        in_chan_cnt,
  input  logic [2:0]        in_die_cnt,
  input  logic [4:0]        in_hash_en,
  input  logic [5:0]        in_ilv_pos,
  input  logic [1:0]        in_sock_cnt,
  output logic              out_valid,
  output logic [63:0]       out_addr,
  output logic              out_err
);
  logic              cfg_err;
  logic [2:0]        chan_bits;
  logic [1:0]        die_bits;
  logic [ADDR_W-1:0] stg [NUM_STAGES+1];

  dhx_check u_check (
    .chan_cnt  (in_chan_cnt),
    .die_cnt   (in_die_cnt),
    .ilv_pos   (in_ilv_pos),
    .sock_cnt  (in_sock_cnt),
    .err       (cfg_err),
    .chan_bits (chan_bits),
    .die_bits  (die_bits)
  );

  assign stg[0] = in_addr;

  // Channel stages first, then die stages, each on the running address.
  for (genvar k = 0; k < CHAN_MAX_BITS; k++) begin : g_chan
    logic act;
    assign act = !cfg_err && (k < int'(chan_bits));
    dhx_fix_bit #(
      .BASE (chan_base(k)), .T4K (chan_t4k(k)),
      .T64K (15 + k), .T2M (22 + k), .T1G (29 + k),
      .T1TA (36 + k), .T1TB (43 + k)
    ) u_fix (
      .act (act), .en (in_hash_en), .a_i (stg[k]), .a_o (stg[k+1])
    );
  end

  for (genvar j = 0; j < DIE_MAX_BITS; j++) begin : g_die
    logic act;
    assign act = !cfg_err && (j < int'(die_bits));
    dhx_fix_bit #(
      .BASE (12 + j), .T4K (-1),
      .T64K (20 + j), .T2M (27 + j), .T1G (34 + j),
      .T1TA (41 + j), .T1TB (-1)
    ) u_fix (
      .act (act), .en (in_hash_en),
      .a_i (stg[CHAN_MAX_BITS+j]), .a_o (stg[CHAN_MAX_BITS+j+1])
    );
  end

  dhx_oreg u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (in_valid),
    .d_addr  (stg[NUM_STAGES]),
    .d_err   (cfg_err),
    .q_valid (out_valid),
    .q_addr  (out_addr),
    .q_err   (out_err)
  );
endmodule

// File: rtl/dhx_sva.sv
module dhx_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_addr,
  input logic [5:0]  in_chan_cnt,
  input logic [2:0]  in_die_cnt,
  input logic [4:0]  in_hash_en,
  input logic [5:0]  in_ilv_pos,
  input logic [1:0]  in_sock_cnt,
  input logic        out_valid,
  input logic [63:0] out_addr,
  input logic        out_err
);
  localparam logic [63:0] SEL_MASK = 64'h0000_0000_0000_7F00;

  assert_err_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_ilv_pos != 6'd8 || in_sock_cnt > 2'd1)
      |=> out_err && out_addr == $past(in_addr));

  assert_err_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !(in_chan_cnt inside {6'd8, 6'd16, 6'd32})
      |=> out_err && out_addr == $past(in_addr));

  assert_chan8_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_chan_cnt == 6'd8
      |=> out_addr[11] == $past(in_addr[11]) && out_addr[14] == $past(in_addr[14]));

  assert_die1_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_die_cnt == 3'd1
      |=> out_addr[13:12] == $past(in_addr[13:12]));

  assert_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_addr ^ $past(in_addr)) & ~SEL_MASK) == 64'd0);

  assert_no_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_hash_en == 5'd0 |=> out_addr == $past(in_addr));

  assert_vld_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_vld_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_addr) && $stable(out_err));
endmodule

bind stack_dehash dhx_sva u_sva (.*);

// File: tb/tb_stack_dehash.sv
module tb_stack_dehash;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_addr;
  logic [5:0]  in_chan_cnt;
  logic [2:0]  in_die_cnt;
  logic [4:0]  in_hash_en;
  logic [5:0]  in_ilv_pos;
  logic [1:0]  in_sock_cnt;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        out_err;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_dehash dut (.*);

  function automatic logic [63:0] bit_at(input int p);
    return 64'd1 << p;
  endfunction

  // Reference model written from the requirements.
  function automatic logic [64:0] model(input logic [63:0] a_in, input logic [5:0] cc,
      input logic [2:0] dc, input logic [4:0] en, input logic [5:0] pos, input logic [1:0] sk);
    logic [63:0] a;
    int nc, nd;
    logic h;
    a = a_in;
    if (pos != 6'd8 || sk > 2'd1 || !(dc inside {3'd1, 3'd2, 3'd4}) ||
        !(cc inside {6'd8, 6'd16, 6'd32}))
      return {1'b1, a_in};
    nc = (cc == 6'd8) ? 3 : (cc == 6'd16) ? 4 : 5;
    nd = (dc == 3'd4) ? 2 : (dc == 3'd2) ? 1 : 0;
    for (int i = 0; i < nc; i++) begin
      h = (i <= 2) ? (en[0] & a[12+i]) : 1'b0;
      h ^= en[1] & a[15+i];
      h ^= en[2] & a[22+i];
      h ^= en[3] & a[29+i];
      h ^= en[4] & (a[36+i] ^ a[43+i]);
      if (h) a[(i == 4) ? 14 : 8+i] ^= 1'b1;
    end
    for (int i = 0; i < nd; i++) begin
      h = (en[1] & a[20+i]) ^ (en[2] & a[27+i]) ^ (en[3] & a[34+i]) ^ (en[4] & a[41+i]);
      if (h) a[12+i] ^= 1'b1;
    end
    return {1'b0, a};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive one request at a falling edge, return the result one cycle later.
  task automatic run(input logic [63:0] a, input logic [5:0] cc, input logic [2:0] dc,
      input logic [4:0] en, input logic [5:0] pos, input logic [1:0] sk,
      output logic [63:0] ra, output logic re);
    in_valid = 1'b1; in_addr = a; in_chan_cnt = cc; in_die_cnt = dc;
    in_hash_en = en; in_ilv_pos = pos; in_sock_cnt = sk;
    @(negedge clk);
    in_valid = 1'b0;
    ra = out_addr; re = out_err;
    check("R9 out_valid after request", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset();
    check("R9 out_valid at reset", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_no_enable();
    logic [63:0] r; logic e;
    run(64'hFFFF_FFFF_FFFF_FFFF, 6'd32, 3'd4, 5'd0, 6'd8, 2'd1, r, e);
    check("R8 no enables leaves address", r, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2 valid setting no error", {63'd0, e}, 64'd0);
  endtask

  task automatic t_4k_terms();
    logic [63:0] r; logic e;
    run(bit_at(12), 6'd8, 3'd1, 5'b00001, 6'd8, 2'd0, r, e);
    check("R4 4K bit12 flips bit8", r, bit_at(12) | bit_at(8));
    run(bit_at(14), 6'd8, 3'd1, 5'b00001, 6'd8, 2'd0, r, e);
    check("R4 4K bit14 flips bit10", r, bit_at(14) | bit_at(10));
    run(bit_at(15), 6'd32, 3'd1, 5'b00001, 6'd8, 2'd0, r, e);
    check("R4 no 4K term for channel bit 3", r, bit_at(15));
  endtask

  task automatic t_chan_terms();
    logic [63:0] r; logic e;
    run(bit_at(18), 6'd16, 3'd1, 5'b00010, 6'd8, 2'd0, r, e);
    check("R5 64K bit18 flips bit11", r, bit_at(18) | bit_at(11));
    run(bit_at(23), 6'd8, 3'd1, 5'b00100, 6'd8, 2'd0, r, e);
    check("R5 2M bit23 flips bit9", r, bit_at(23) | bit_at(9));
    run(bit_at(31), 6'd8, 3'd1, 5'b01000, 6'd8, 2'd0, r, e);
    check("R5 1G bit31 flips bit10", r, bit_at(31) | bit_at(10));
    run(bit_at(43), 6'd8, 3'd1, 5'b10000, 6'd8, 2'd0, r, e);
    check("R5 1T upper term flips bit8", r, bit_at(43) | bit_at(8));
    run(bit_at(36) | bit_at(43), 6'd8, 3'd1, 5'b10000, 6'd8, 2'd0, r, e);
    check("R7 two 1T terms cancel", r, bit_at(36) | bit_at(43));
    run(bit_at(23), 6'd8, 3'd1, 5'b01011, 6'd8, 2'd0, r, e);
    check("R7 disabled 2M term ignored", r, bit_at(23));
  endtask

  task automatic t_chan_count();
    logic [63:0] r; logic e;
    run(bit_at(19), 6'd32, 3'd1, 5'b00010, 6'd8, 2'd0, r, e);
    check("R3 channel bit 4 at bit14", r, bit_at(19) | bit_at(14));
    run(bit_at(19), 6'd16, 3'd1, 5'b00010, 6'd8, 2'd0, r, e);
    check("R3 16 channels leave bit14", r, bit_at(19));
    run(bit_at(18), 6'd8, 3'd1, 5'b00010, 6'd8, 2'd0, r, e);
    check("R3 8 channels leave bit11", r, bit_at(18));
  endtask

  task automatic t_die();
    logic [63:0] r; logic e;
    run(bit_at(21), 6'd8, 3'd4, 5'b00010, 6'd8, 2'd0, r, e);
    check("R6 4 dies 64K bit21 flips bit13", r, bit_at(21) | bit_at(13));
    run(bit_at(21), 6'd8, 3'd2, 5'b00010, 6'd8, 2'd0, r, e);
    check("R6 2 dies leave bit13", r, bit_at(21));
    run(bit_at(41), 6'd8, 3'd2, 5'b10000, 6'd8, 2'd0, r, e);
    check("R6 1T bit41 flips bit12", r, bit_at(41) | bit_at(12));
    run(bit_at(12), 6'd8, 3'd4, 5'b00001, 6'd8, 2'd0, r, e);
    check("R7 channel reads die bit before die step", r, bit_at(12) | bit_at(8));
  endtask

  task automatic t_errors();
    logic [63:0] r; logic e;
    run(bit_at(12), 6'd8, 3'd1, 5'b00001, 6'd9, 2'd0, r, e);
    check("R1 position 9 passes through", r, bit_at(12));
    check("R1 position 9 error", {63'd0, e}, 64'd1);
    run(bit_at(12), 6'd8, 3'd1, 5'b00001, 6'd8, 2'd2, r, e);
    check("R1 two sockets error", {63'd0, e}, 64'd1);
    run(bit_at(12), 6'd8, 3'd3, 5'b00001, 6'd8, 2'd0, r, e);
    check("R1 three dies error", {62'd0, e, r[8]}, 64'd2);
    run(bit_at(12), 6'd4, 3'd1, 5'b00001, 6'd8, 2'd0, r, e);
    check("R2 four channels error", {62'd0, e, r[8]}, 64'd2);
  endtask

  task automatic t_hold();
    logic [63:0] held;
    held = out_addr;
    in_addr = ~held;
    @(negedge clk);
    check("R9 idle out_valid low", {63'd0, out_valid}, 64'd0);
    check("R9 idle address held", out_addr, held);
  endtask

  task automatic t_stream();
    logic [64:0] exp_q;
    logic        have = 1'b0;
    logic [5:0]  cc;
    logic [2:0]  dc;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      cc = (lfsr[1:0] == 2'd0) ? 6'd8 : (lfsr[1:0] == 2'd1) ? 6'd16 :
           (lfsr[1:0] == 2'd2) ? 6'd32 : 6'd12;
      dc = (lfsr[3:2] == 2'd0) ? 3'd1 : (lfsr[3:2] == 2'd1) ? 3'd2 : 3'd4;
      in_valid = 1'b1; in_addr = lfsr ^ {lfsr[31:0], lfsr[63:32]};
      in_chan_cnt = cc; in_die_cnt = dc; in_hash_en = lfsr[8:4];
      in_ilv_pos = (lfsr[15:9] == 7'd0) ? 6'd9 : 6'd8; in_sock_cnt = {1'b0, lfsr[16]};
      @(negedge clk);
      exp_q = model(in_addr, in_chan_cnt, in_die_cnt, in_hash_en, in_ilv_pos, in_sock_cnt);
      check("R7 stream address", out_addr, exp_q[63:0]);
      check("R1 R2 stream error", {63'd0, out_err}, {63'd0, exp_q[64]});
      have = 1'b1;
    end
    in_valid = 1'b0;
    if (!have) check("R9 stream ran", 64'd0, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_chan_cnt = 6'd8; in_die_cnt = 3'd1;
    in_hash_en = '0; in_ilv_pos = 6'd8; in_sock_cnt = 2'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_enable();
    t_4k_terms();
    t_chan_terms();
    t_chan_count();
    t_die();
    t_errors();
    t_hold();
    t_stream();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule